// File: doc/BRIEF.md
# PCI Function Base Address Register Bank

This block holds the address-window registers of one PCI function's Type 0 configuration header. There are six 32-bit window slots and one expansion ROM window. Parameters give each slot a kind (unused, 32-bit memory, 64-bit memory or I/O), a size as a power of two and a prefetchable flag. A 64-bit memory window uses its own slot for the low half of the base and the next slot for the high half. Software reads and writes the registers through a DWORD-indexed configuration port. Bits below the window size are not stored, so writing all ones and reading back shows how large the window is.

A second port takes a bus address and a space flag (memory or I/O). One clock later it reports whether the address falls in one of the programmed windows, which window it is, and the byte offset inside that window. Every address bit above the window size is compared, including bits 63:32.

Top module: `pci_bar_file`

## Requirements
- R1: After reset every stored base bit is 0. Each slot reads back only its fixed type bits, and the decode outputs `dec_hit`, `dec_index` and `dec_offset` are all 0.
- R2: Window slot i sits at DWORD index 4+i (byte offset 10h+4i) and the ROM window at DWORD index 12 (byte offset 30h). Every other DWORD index reads 0, and a write to it changes no register.
- R3: A memory slot reads bit 0 as 0, bits [2:1] as 00 for 32-bit or 10 for 64-bit, and bit 3 as its prefetchable flag. An I/O slot reads bits [1:0] as 01. Writes never change these bits.
- R4: A slot of size 2^L keeps only the written bits at positions L and above, and reads 0 in the address bits below L. Writing all ones therefore exposes the size. Memory sizes run from 16 bytes to 2 GB, and I/O sizes start at 4 bytes.
- R5: The slot after a 64-bit memory slot holds base bits [63:32]. Its bits below L-32 are forced to 0, and it reads back what was written. Decoding uses the full 64-bit base.
- R6: An unused slot (kind 0) that is not the high half of a 64-bit pair reads 0, ignores writes and never hits.
- R7: Decode results are registered. For a request presented with `dec_valid` in cycle n, the outputs appear after the next clock edge. `dec_offset` is the address minus the window base. Without a valid request or without a match, all three outputs read 0.
- R8: A match requires every address bit at position L and above, up to bit 63, to equal the stored base. For 32-bit windows this means bits 63:32 must be 0.
- R9: I/O slots match only requests with `dec_io`=1. Memory slots and the ROM window match only requests with `dec_io`=0.
- R10: In the ROM register, bit 0 is a writable enable and bits [10:1] read 0. The minimum ROM size is 2 KB. The ROM window decodes, with index 6, only while the enable bit is 1.
- R11: When windows overlap, the lowest index wins, and the ROM window comes last.
- R12: Configuration read data changes only after a clock edge at which `cfg_we` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration DWORD index (byte offset / 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_dw`, combinational |
| dec_valid | input | 1 | Decode request valid |
| dec_io | input | 1 | Request is in I/O space (1) or memory space (0) |
| dec_addr | input | 64 | Request address |
| dec_hit | output | 1 | Registered: the request matched a window |
| dec_index | output | 3 | Registered: matching slot (0..5) or 6 for ROM |
| dec_offset | output | 64 | Registered: byte offset within the matching window |

## Verification
A wrong write mask shows up on `cfg_rdata` in the same cycle a slot is read after a write. The bench exposes it with a walking-one sweep of every slot. A wrong stored base or comparison width shows up one clock after a probe, as a missing hit, a hit on a neighbouring address or a wrong offset. To catch this, the bench probes each window just below its base, at its base, inside it, at its last byte and just past its end. It also repeats probes with a high address bit flipped and with the space flag flipped. Priority mistakes show up right after reset, when every window starts at base 0 and they all overlap.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
   localparam int unsigned NUM_SLOTS = 6;
   localparam int unsigned ROM_INDEX = NUM_SLOTS;
   localparam int unsigned IDX_W     = $clog2(NUM_SLOTS + 1);
   localparam int unsigned CFG_DW_W  = 6;
   localparam int unsigned SLOT_DW0  = 4;   // byte offset 10h
   localparam int unsigned ROM_DW    = 12;  // byte offset 30h

   typedef enum logic [1:0] {
      BAR_OFF   = 2'd0,
      BAR_MEM32 = 2'd1,
      BAR_MEM64 = 2'd2,
      BAR_IO    = 2'd3
   } bar_kind_e;

   // Writable bits of a low DWORD for a window of 2^l bytes
   function automatic logic [31:0] low_wmask(int unsigned l);
      if (l >= 32) return 32'h0;
      return ~((32'h1 << l) - 32'h1);
   endfunction

   // Writable bits of the high DWORD of a 64-bit window of 2^l bytes
   function automatic logic [31:0] high_wmask(int unsigned l);
      if (l <= 32) return 32'hFFFF_FFFF;
      return ~((32'h1 << (l - 32)) - 32'h1);
   endfunction

   // Offset bits of a window of 2^l bytes
   function automatic logic [63:0] span_mask(int unsigned l);
      if (l >= 64) return 64'hFFFF_FFFF_FFFF_FFFF;
      return (64'h1 << l) - 64'h1;
   endfunction

   // Read-only type bits of a slot
   function automatic logic [31:0] attr_bits(logic [1:0] kind, logic pref);
      case (kind)
         BAR_MEM32: return {28'h0, pref, 3'b000};
         BAR_MEM64: return {28'h0, pref, 3'b100};
         BAR_IO:    return 32'h1;
         default:   return 32'h0;
      endcase
   endfunction
endpackage

// File: rtl/pci_bar_slot.sv
module pci_bar_slot
   import pci_bar_pkg::*;
#(
   parameter logic [31:0] WMASK = 32'h0,
   parameter logic [31:0] ATTR  = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic [31:0] base_bits
);
   logic [31:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     base_q <= 32'h0;
      else if (wr_en) base_q <= wr_data & WMASK;
   end

   assign base_bits = base_q;
   assign rd_data   = base_q | ATTR;
endmodule

// File: rtl/pci_bar_match.sv
module pci_bar_match
   import pci_bar_pkg::*;
#(
   parameter int unsigned LOG2     = 12,
   parameter bit          IO_SPACE = 1'b0
) (
   input  logic        enable,
   input  logic [63:0] base,
   input  logic [63:0] addr,
   input  logic        is_io,
   output logic        hit,
   output logic [63:0] offset
);
   localparam logic [63:0] SPAN = span_mask(LOG2);

   assign hit    = enable && (is_io == IO_SPACE) && (((addr ^ base) & ~SPAN) == 64'h0);
   assign offset = addr & SPAN;
endmodule

// File: rtl/pci_bar_file.sv
module pci_bar_file
   import pci_bar_pkg::*;
#(
   parameter logic [NUM_SLOTS-1:0][1:0] SLOT_KIND = {2'd1, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1},
   parameter logic [NUM_SLOTS-1:0][5:0] SLOT_LOG2 = {6'd4, 6'd0, 6'd0, 6'd20, 6'd5, 6'd12},
   parameter logic [NUM_SLOTS-1:0]      SLOT_PREF = 6'b100100,
   parameter int unsigned               ROM_LOG2  = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_DW_W-1:0] cfg_dw,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic                dec_valid,
   input  logic                dec_io,
   input  logic [63:0]         dec_addr,
   output logic                dec_hit,
   output logic [IDX_W-1:0]    dec_index,
   output logic [63:0]         dec_offset
);
   localparam int unsigned NUM_WIN = NUM_SLOTS + 1;

   logic [31:0]        slot_rd  [NUM_SLOTS];
   logic [31:0]        slot_val [NUM_SLOTS];
   logic [NUM_WIN-1:0] win_hit;
   logic [63:0]        win_off  [NUM_WIN];
   logic [31:0]        rom_rd;

   // ---------------- window slots ----------------
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      localparam int unsigned PREV  = (i > 0) ? i - 1 : 0;
      localparam int unsigned NEXT  = (i < NUM_SLOTS - 1) ? i + 1 : i;
      localparam logic [1:0]  KIND  = SLOT_KIND[i];
      localparam int unsigned LOG2  = SLOT_LOG2[i];
      localparam bit          UPPER = (i > 0) && (SLOT_KIND[PREV] == BAR_MEM64);
      localparam logic [31:0] WMASK = UPPER ? high_wmask(SLOT_LOG2[PREV]) :
                                      (KIND == BAR_OFF) ? 32'h0 : low_wmask(LOG2);
      localparam logic [31:0] ATTR  = UPPER ? 32'h0 : attr_bits(KIND, SLOT_PREF[i]);

      if (UPPER && KIND != BAR_OFF) begin : g_bad_pair
         $error("slot after a 64-bit window must be configured unused");
      end
      if (KIND == BAR_MEM64 && i == NUM_SLOTS - 1) begin : g_bad_last
         $error("64-bit window cannot occupy the last slot");
      end
      if (KIND == BAR_MEM32 && (LOG2 < 4 || LOG2 > 31)) begin : g_bad_m32
         $error("32-bit memory window size out of range");
      end
      if (KIND == BAR_MEM64 && (LOG2 < 4 || LOG2 > 63)) begin : g_bad_m64
         $error("64-bit memory window size out of range");
      end
      if (KIND == BAR_IO && (LOG2 < 2 || LOG2 > 31)) begin : g_bad_io
         $error("I/O window size out of range");
      end

      pci_bar_slot #(
         .WMASK (WMASK),
         .ATTR  (ATTR)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && (cfg_dw == CFG_DW_W'(SLOT_DW0 + i))),
         .wr_data   (cfg_wdata),
         .rd_data   (slot_rd[i]),
         .base_bits (slot_val[i])
      );

      if (KIND != BAR_OFF && !UPPER) begin : g_win
         logic [63:0] base64;
         if (KIND == BAR_MEM64) begin : g_wide
            assign base64 = {slot_val[NEXT], slot_val[i]};
         end else begin : g_narrow
            assign base64 = {32'h0, slot_val[i]};
         end
         pci_bar_match #(
            .LOG2     (LOG2),
            .IO_SPACE (KIND == BAR_IO)
         ) u_match (
            .enable (1'b1),
            .base   (base64),
            .addr   (dec_addr),
            .is_io  (dec_io),
            .hit    (win_hit[i]),
            .offset (win_off[i])
         );
      end else begin : g_nowin
         assign win_hit[i] = 1'b0;
         assign win_off[i] = 64'h0;
      end
   end

   // ---------------- expansion ROM window ----------------
   if (ROM_LOG2 != 0) begin : g_rom
      logic [31:0] rom_val;
      if (ROM_LOG2 < 11 || ROM_LOG2 > 31) begin : g_bad_rom
         $error("ROM window size out of range");
      end
      pci_bar_slot #(
         .WMASK (low_wmask(ROM_LOG2) | 32'h1),
         .ATTR  (32'h0)
      ) u_rom (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && (cfg_dw == CFG_DW_W'(ROM_DW))),
         .wr_data   (cfg_wdata),
         .rd_data   (rom_rd),
         .base_bits (rom_val)
      );
      pci_bar_match #(
         .LOG2     (ROM_LOG2),
         .IO_SPACE (1'b0)
      ) u_match (
         .enable (rom_val[0]),
         .base   ({32'h0, rom_val[31:1], 1'b0}),
         .addr   (dec_addr),
         .is_io  (dec_io),
         .hit    (win_hit[ROM_INDEX]),
         .offset (win_off[ROM_INDEX])
      );
   end else begin : g_norom
      assign rom_rd             = 32'h0;
      assign win_hit[ROM_INDEX] = 1'b0;
      assign win_off[ROM_INDEX] = 64'h0;
   end

   // ---------------- configuration read ----------------
   always_comb begin
      cfg_rdata = 32'h0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (cfg_dw == CFG_DW_W'(SLOT_DW0 + k)) cfg_rdata = slot_rd[k];
      end
      if (cfg_dw == CFG_DW_W'(ROM_DW)) cfg_rdata = rom_rd;
   end

   // ---------------- priority pick and output register ----------------
   logic             pick_hit;
   logic [IDX_W-1:0] pick_idx;
   logic [63:0]      pick_off;

   always_comb begin
      pick_hit = 1'b0;
      pick_idx = '0;
      pick_off = 64'h0;
      for (int k = NUM_WIN - 1; k >= 0; k--) begin
         if (win_hit[k]) begin
            pick_hit = 1'b1;
            pick_idx = IDX_W'(k);
            pick_off = win_off[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_hit    <= 1'b0;
         dec_index  <= '0;
         dec_offset <= 64'h0;
      end else if (dec_valid && pick_hit) begin
         dec_hit    <= 1'b1;
         dec_index  <= pick_idx;
         dec_offset <= pick_off;
      end else begin
         dec_hit    <= 1'b0;
         dec_index  <= '0;
         dec_offset <= 64'h0;
      end
   end
endmodule

// File: rtl/pci_bar_file_chk.sv
module pci_bar_file_chk
   import pci_bar_pkg::*;
#(
   parameter logic [NUM_SLOTS-1:0][1:0] SLOT_KIND = '0,
   parameter logic [NUM_SLOTS-1:0][5:0] SLOT_LOG2 = '0,
   parameter int unsigned               ROM_LOG2  = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [CFG_DW_W-1:0] cfg_dw,
   input logic [31:0]         cfg_rdata,
   input logic                dec_valid,
   input logic                dec_hit,
   input logic [IDX_W-1:0]    dec_index,
   input logic [63:0]         dec_offset
);
   function automatic int unsigned idx_log2(logic [IDX_W-1:0] idx);
      if (idx == IDX_W'(ROM_INDEX)) return ROM_LOG2;
      if (idx < IDX_W'(NUM_SLOTS)) return SLOT_LOG2[idx];
      return 0;
   endfunction

   function automatic logic idx_is_window(logic [IDX_W-1:0] idx);
      if (idx == IDX_W'(ROM_INDEX)) return ROM_LOG2 != 0;
      if (idx >= IDX_W'(NUM_SLOTS)) return 1'b0;
      if (SLOT_KIND[idx] == BAR_OFF) return 1'b0;
      if (idx != '0 && SLOT_KIND[idx - 1'b1] == BAR_MEM64) return 1'b0;
      return 1'b1;
   endfunction

   AST_HIT_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> $past(dec_valid));  // R7

   AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (dec_index == '0 && dec_offset == 64'h0));  // R7

   AST_HIT_ON_LIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> idx_is_window(dec_index));  // R6

   AST_OFFSET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> ((dec_offset & ~span_mask(idx_log2(dec_index))) == 64'h0));  // R4

   AST_READ_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && $stable(cfg_dw)) |-> $stable(cfg_rdata));  // R12
endmodule

bind pci_bar_file pci_bar_file_chk #(
   .SLOT_KIND (SLOT_KIND),
   .SLOT_LOG2 (SLOT_LOG2),
   .ROM_LOG2  (ROM_LOG2)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_dw     (cfg_dw),
   .cfg_rdata  (cfg_rdata),
   .dec_valid  (dec_valid),
   .dec_hit    (dec_hit),
   .dec_index  (dec_index),
   .dec_offset (dec_offset)
);

// File: tb/pci_bar_file_test.sv
module pci_bar_file_test;
   // Bench configuration: slot kinds 0 unused, 1 mem32, 2 mem64, 3 io
   localparam int K [6] = '{1, 3, 2, 0, 0, 1};
   localparam int L [6] = '{12, 5, 20, 0, 0, 4};
   localparam int P [6] = '{0, 0, 1, 0, 0, 1};
   localparam int ROML  = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_dw = 6'd0;
   logic [31:0] cfg_wdata = 32'h0;
   logic [31:0] cfg_rdata;
   logic        dec_valid = 1'b0;
   logic        dec_io = 1'b0;
   logic [63:0] dec_addr = 64'h0;
   logic        dec_hit;
   logic [2:0]  dec_index;
   logic [63:0] dec_offset;

   int total = 0;
   int fails = 0;
   logic [31:0] model [7];

   always #4 clk = ~clk;

   pci_bar_file #(
      .SLOT_KIND ({2'd1, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1}),
      .SLOT_LOG2 ({6'd4, 6'd0, 6'd0, 6'd20, 6'd5, 6'd12}),
      .SLOT_PREF (6'b100100),
      .ROM_LOG2  (ROML)
   ) uut (
      .clk, .rst_n, .cfg_we, .cfg_dw, .cfg_wdata, .cfg_rdata,
      .dec_valid, .dec_io, .dec_addr, .dec_hit, .dec_index, .dec_offset
   );

   // ---------- arithmetic reference ----------
   function automatic logic [31:0] lo_m(int l);
      return (l >= 32) ? 32'h0 : (32'hFFFF_FFFF << l);
   endfunction
   function automatic logic [31:0] hi_m(int l);
      return (l <= 32) ? 32'hFFFF_FFFF : (32'hFFFF_FFFF << (l - 32));
   endfunction
   function automatic bit is_upper(int s);
      return (s > 0) && (K[s > 0 ? s - 1 : 0] == 2);
   endfunction
   function automatic logic [31:0] wmask(int s);
      if (s == 6) return lo_m(ROML) | 32'h1;
      if (is_upper(s)) return hi_m(L[s - 1]);
      if (K[s] == 0) return 32'h0;
      return lo_m(L[s]);
   endfunction
   function automatic logic [31:0] attr(int s);
      if (s == 6 || is_upper(s)) return 32'h0;
      case (K[s])
         1: return 32'(P[s] * 8);
         2: return 32'(P[s] * 8 + 4);
         3: return 32'h1;
         default: return 32'h0;
      endcase
   endfunction
   function automatic logic [31:0] exp_rd(int dw);
      int s;
      if (dw >= 4 && dw <= 9) s = dw - 4;
      else if (dw == 12) s = 6;
      else return 32'h0;
      return (model[s] & wmask(s)) | attr(s);
   endfunction
   function automatic bit win_live(int s);
      if (s == 6) return model[6][0];
      return (K[s] != 0) && !is_upper(s);
   endfunction
   function automatic int win_log2(int s);
      return (s == 6) ? ROML : L[s];
   endfunction
   function automatic logic [63:0] win_base(int s);
      logic [63:0] b;
      b = {32'h0, model[s] & lo_m(win_log2(s))};
      if (s < 6 && K[s] == 2) b[63:32] = model[s + 1] & hi_m(L[s]);
      return b;
   endfunction
   function automatic bit win_io(int s);
      return (s < 6) && (K[s] == 3);
   endfunction
   task automatic exp_decode(input logic [63:0] a, input logic io,
                             output logic h, output logic [2:0] ix, output logic [63:0] o);
      h = 1'b0; ix = 3'd0; o = 64'h0;
      for (int s = 0; s < 7; s++) begin
         if (!h && win_live(s) && (win_io(s) == io) && (a >= win_base(s))
             && ((a - win_base(s)) < (64'd1 << win_log2(s)))) begin
            h = 1'b1; ix = 3'(s); o = a - win_base(s);
         end
      end
   endtask

   // ---------- checking ----------
   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int dw, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_dw = 6'(dw); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (dw >= 4 && dw <= 9) model[dw - 4] = d;
      else if (dw == 12) model[6] = d;
   endtask

   task automatic cfg_check(input int dw, input string tag);
      @(negedge clk);
      cfg_dw = 6'(dw);
      #1;
      check($sformatf("%s read dw=%0d", tag, dw), {32'h0, cfg_rdata}, {32'h0, exp_rd(dw)});
   endtask

   task automatic probe(input logic [63:0] a, input logic io, input string tag);
      logic eh; logic [2:0] ei; logic [63:0] eo;
      exp_decode(a, io, eh, ei, eo);
      @(negedge clk);
      dec_valid = 1'b1; dec_addr = a; dec_io = io;
      @(negedge clk);
      dec_valid = 1'b0;
      check($sformatf("%s hit a=%h io=%0b", tag, a, io), {63'h0, dec_hit}, {63'h0, eh});
      check($sformatf("%s index a=%h", tag, a), {61'h0, dec_index}, {61'h0, ei});
      check($sformatf("%s offset a=%h", tag, a), dec_offset, eo);
   endtask

   function automatic string slot_tag(int dw);
      if (dw == 7) return "R5";
      if (dw == 8) return "R6";
      if (dw == 12) return "R10";
      return "R4";
   endfunction

   // ---------- watchdog ----------
   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   // ---------- stimulus ----------
   initial begin
      for (int s = 0; s < 7; s++) model[s] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 dec_hit after reset", {63'h0, dec_hit}, 64'h0);
      check("R1 dec_index after reset", {61'h0, dec_index}, 64'h0);
      check("R1 dec_offset after reset", dec_offset, 64'h0);
      for (int dw = 4; dw <= 12; dw++) if (dw <= 9 || dw == 12) cfg_check(dw, "R1");
      cfg_check(8, "R6 unused slot after reset");

      // R11: all windows at base 0 overlap
      probe(64'h8, 1'b0, "R11 overlap low");
      probe(64'h2000, 1'b0, "R11 only 64-bit window");
      probe(64'h10_0000, 1'b0, "R11 past all");
      probe(64'h4, 1'b1, "R11 io at zero");
      probe(64'h0, 1'b0, "R10 rom disabled at reset");

      // R4/R5/R6/R10: sizing by all ones
      for (int dw = 4; dw <= 12; dw++) if (dw <= 9 || dw == 12) begin
         cfg_write(dw, 32'hFFFF_FFFF);
         cfg_check(dw, slot_tag(dw));
      end
      // R3: fixed bits survive a zero write
      for (int dw = 4; dw <= 12; dw++) if (dw <= 9 || dw == 12) begin
         cfg_write(dw, 32'h0);
         cfg_check(dw, "R3");
      end
      // walking-one sweep over every slot
      for (int dw = 4; dw <= 12; dw++) if (dw <= 9 || dw == 12) begin
         for (int b = 0; b < 32; b++) begin
            cfg_write(dw, 32'h1 << b);
            cfg_check(dw, (b < 4) ? "R3" : slot_tag(dw));
         end
      end

      // R2: other DWORD indices read 0 and touch nothing
      for (int dw = 0; dw < 16; dw++) if (dw < 4 || (dw > 9 && dw != 12)) begin
         cfg_write(dw, 32'hFFFF_FFFF);
         cfg_check(dw, "R2");
         cfg_check(4, "R2 slot0 untouched");
         cfg_check(12, "R2 rom untouched");
      end

      // program windows
      cfg_write(4, 32'h8000_0000);
      cfg_write(5, 32'h0000_1000);
      cfg_write(6, 32'h3450_0000);
      cfg_write(7, 32'h0000_0012);
      cfg_write(8, 32'hFFFF_FFFF);
      cfg_write(9, 32'h4000_0010);
      cfg_write(12, 32'h9000_0800);
      cfg_check(7, "R5 high half");
      cfg_check(8, "R6 ignores write");

      // R10: ROM disabled then enabled
      probe(64'h9000_0800, 1'b0, "R10 rom disabled");
      cfg_write(12, 32'h9000_0801);
      cfg_check(12, "R10 enable bit");

      // boundary sweep over every live window
      for (int s = 0; s < 7; s++) if (win_live(s)) begin
         automatic logic [63:0] b = win_base(s);
         automatic logic [63:0] sz = 64'd1 << win_log2(s);
         probe(b - 64'd1, win_io(s), "R7 below base");
         probe(b, win_io(s), "R7 base");
         probe(b + 64'd1, win_io(s), "R7 base+1");
         probe(b + sz / 2, win_io(s), "R7 middle");
         probe(b + sz - 64'd1, win_io(s), "R4 last byte");
         probe(b + sz, win_io(s), "R4 past end");
         probe(b ^ (64'h1 << 40), win_io(s), "R8 bit40 flipped");
         probe(b ^ (64'h1 << 32), win_io(s), "R8 bit32 flipped");
         probe(b, !win_io(s), "R9 wrong space");
      end
      probe(64'h12_3450_0000, 1'b0, "R5 64-bit base");
      probe(64'h13_3450_0000, 1'b0, "R5 64-bit upper mismatch");

      // slot 5 (16-byte window) full offset sweep
      for (int d = -16; d < 32; d++)
         probe(64'h4000_0010 + 64'(signed'(d)), 1'b0, "R4 small window sweep");

      // R7: registered timing and idle behaviour
      @(negedge clk);
      dec_valid = 1'b1; dec_addr = 64'h8000_0123; dec_io = 1'b0;
      #1;
      check("R7 no hit before edge", {63'h0, dec_hit}, 64'h0);
      @(negedge clk);
      dec_valid = 1'b0;
      check("R7 hit after edge", {63'h0, dec_hit}, 64'h1);
      check("R7 offset after edge", dec_offset, 64'h123);
      @(negedge clk);
      check("R7 hit drops", {63'h0, dec_hit}, 64'h0);
      check("R7 offset idle", dec_offset, 64'h0);
      @(negedge clk);
      check("R7 no valid no hit", {63'h0, dec_hit}, 64'h0);

      // R12: contents held over decode traffic
      for (int dw = 4; dw <= 12; dw++) if (dw <= 9 || dw == 12) cfg_check(dw, "R12");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule